// File: doc/BRIEF.md
# Down-Growing Hardware Stack

This block is a last-in, first-out store kept in an internal register array. A pointer register marks the entry that currently sits on top of the stack. Entries fill from the highest address downward. A push first moves the pointer down one place and then writes the incoming word into the slot the pointer now names. A pop copies the top word into an output register and then moves the pointer up one place.

Two status bits follow the pointer. The full bit means the pointer has reached zero, so every slot is in use. The empty bit means the pointer has gone back to the stack depth, its value after reset. An operation that cannot be carried out changes nothing and raises an error pulse for one cycle. That covers a push while full and a pop while empty. When push and pop are requested in the same cycle, the pop is performed and the push is dropped.

The asynchronous active-low reset is released through a two-stage synchronizer. The block starts responding on the third rising edge after the reset input goes high.

Top module: `lifo_down_stack`

## Requirements
- R1: After reset the pointer equals DEPTH, empty is 1, full is 0, the error pulse is 0 and the data output is 0.
- R2: An accepted push lowers the pointer by exactly one, stores the input word at the new pointer value and clears empty.
- R3: An accepted pop loads the word at the current pointer into the data output, raises the pointer by exactly one and clears full.
- R4: Full is 1 exactly when the pointer is 0, which happens after DEPTH accepted pushes from the empty state.
- R5: Empty is 1 exactly when the pointer equals DEPTH.
- R6: A push while full leaves the pointer, the flags and the stored words unchanged, and raises the error output for exactly one cycle.
- R7: A pop while empty leaves the pointer, the flags and the data output unchanged, and raises the error output for exactly one cycle.
- R8: When push and pop are both asserted, only the pop takes effect and the input word is not stored. An error is raised only if the stack is empty.
- R9: Words come back in the reverse of the order in which they were pushed.
- R10: The data output keeps its value through cycles with no accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| push_i | input | 1 | Push request |
| pop_i | input | 1 | Pop request (has priority over push) |
| din_i | input | WIDTH | Word to push |
| dout_o | output | WIDTH | Registered word from the most recent pop |
| sp_o | output | $clog2(DEPTH+1) | Stack pointer, indexing the top entry |
| full_o | output | 1 | Pointer is 0 |
| empty_o | output | 1 | Pointer equals DEPTH |
| err_o | output | 1 | One-cycle pulse for a rejected push or pop |

## Verification
A pointer that is off by one shows at the ports in two ways. sp_o reads wrong on the cycle after the operation. The returned words appear in the wrong order, or hold stale array data, on the very next pop. If a flag drifts away from the pointer, full_o or empty_o disagrees with sp_o on the same cycle, so the tests compare all three after every step. A push that slips through while the stack is full, or while a pop is active, corrupts a stored word. That damage stays hidden until the slot is popped, so every scenario drains the stack and checks each word.

// File: rtl/lifo_pkg.sv
package lifo_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_REJ  = 2'd3
  } stk_op_e;
endpackage

// File: rtl/lifo_rst_sync.sv
module lifo_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lifo_ctrl.sv
module lifo_ctrl
  import lifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          wr_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          rd_en_o,
  output logic [AW-1:0] rd_addr_o,
  output logic [PW-1:0] sp_o,
  output logic          full_o,
  output logic          empty_o,
  output logic          err_o
);
  localparam logic [PW-1:0] SP_MAX = PW'(DEPTH);
  localparam logic [PW-1:0] SP_ONE = PW'(1);

  logic [PW-1:0] sp_q, sp_d;
  logic          full_q, full_d;
  logic          empty_q, empty_d;
  logic          err_q, err_d;
  logic [PW-1:0] sp_dec;
  stk_op_e       op;

  assign sp_dec = sp_q - SP_ONE;

  // operation select: pop wins over push
  always_comb begin
    if (pop_i)       op = empty_q ? OP_REJ : OP_POP;
    else if (push_i) op = full_q  ? OP_REJ : OP_PUSH;
    else             op = OP_IDLE;
  end

  always_comb begin
    sp_d    = sp_q;
    full_d  = full_q;
    empty_d = empty_q;
    err_d   = 1'b0;
    unique case (op)
      OP_PUSH: begin
        sp_d    = sp_dec;
        empty_d = 1'b0;
        full_d  = (sp_dec == '0);
      end
      OP_POP: begin
        sp_d    = sp_q + SP_ONE;
        full_d  = 1'b0;
        empty_d = ((sp_q + SP_ONE) == SP_MAX);
      end
      OP_REJ:  err_d = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= SP_MAX;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
      err_q   <= 1'b0;
    end else begin
      sp_q    <= sp_d;
      full_q  <= full_d;
      empty_q <= empty_d;
      err_q   <= err_d;
    end
  end

  assign wr_en_o   = (op == OP_PUSH);
  assign wr_addr_o = AW'(sp_dec);
  assign rd_en_o   = (op == OP_POP);
  assign rd_addr_o = AW'(sp_q);
  assign sp_o      = sp_q;
  assign full_o    = full_q;
  assign empty_o   = empty_q;
  assign err_o     = err_q;
endmodule

// File: rtl/lifo_store.sv
module lifo_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_en_i,
  input  logic [AW-1:0]    rd_addr_i,
  output logic [WIDTH-1:0] rd_data_o
);
  logic [WIDTH-1:0] slot_q [DEPTH];
  logic [WIDTH-1:0] dout_q, dout_d;

  // array has no reset: contents are undefined until written
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en_i && (wr_addr_i == AW'(g))) slot_q[g] <= wr_data_i;
    end
  end

  always_comb begin
    dout_d = dout_q;
    if (rd_en_i) dout_d = slot_q[rd_addr_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign rd_data_o = dout_q;
endmodule

// File: rtl/lifo_down_stack.sv
module lifo_down_stack #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [PW-1:0]    sp_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             err_o
);
  logic          rst_sync_n;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;

  lifo_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push_i    (push_i),
    .pop_i     (pop_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .sp_o      (sp_o),
    .full_o    (full_o),
    .empty_o   (empty_o),
    .err_o     (err_o)
  );

  lifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (din_i),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (dout_o)
  );
endmodule

// File: rtl/lifo_down_stack_chk.sv
module lifo_down_stack_chk #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16,
  parameter int PW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_i,
  input logic             pop_i,
  input logic [WIDTH-1:0] dout_o,
  input logic [PW-1:0]    sp_o,
  input logic             full_o,
  input logic             empty_o,
  input logic             err_o
);
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && !full_o) |=> (sp_o == $past(sp_o) - PW'(1)) && !empty_o); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_o) |=> (sp_o == $past(sp_o) + PW'(1)) && !full_o); // R3
  AST_FULL_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    full_o == (sp_o == '0)); // R4
  AST_EMPTY_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o == (sp_o == PW'(DEPTH))); // R5
  AST_OVERFLOW_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i && full_o) |=> $stable(sp_o) && err_o); // R6
  AST_UNDERFLOW_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && empty_o) |=> $stable(sp_o) && $stable(dout_o) && err_o); // R7
  AST_POP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !empty_o) |=> (sp_o == $past(sp_o) + PW'(1)) && !err_o); // R8
  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_i |=> $stable(dout_o)); // R10
endmodule

bind lifo_down_stack lifo_down_stack_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH), .PW(PW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .push_i  (push_i),
  .pop_i   (pop_i),
  .dout_o  (dout_o),
  .sp_o    (sp_o),
  .full_o  (full_o),
  .empty_o (empty_o),
  .err_o   (err_o)
);

// File: tb/lifo_down_stack_tb.sv
module lifo_down_stack_tb;
  localparam int DEPTH = 8;
  localparam int WIDTH = 16;
  localparam int PW = $clog2(DEPTH + 1);
  localparam int CLK_PERIOD = 10;

  logic             clk;
  logic             rst_n;
  logic             push_i, pop_i;
  logic [WIDTH-1:0] din_i;
  logic [WIDTH-1:0] dout_o;
  logic [PW-1:0]    sp_o;
  logic             full_o, empty_o, err_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  lifo_down_stack #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i), .din_i(din_i),
    .dout_o(dout_o), .sp_o(sp_o), .full_o(full_o), .empty_o(empty_o), .err_o(err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one cycle of stimulus; outputs reflect it at the following negedge
  task automatic step(input logic ps, input logic pp, input logic [WIDTH-1:0] d);
    @(negedge clk);
    push_i = ps; pop_i = pp; din_i = d;
    @(negedge clk);
    push_i = 1'b0; pop_i = 1'b0; din_i = '0;
  endtask

  task automatic check_status(input string req, input int sp, input bit err);
    check(req, "sp", sp_o, sp);
    check(req, "full", full_o, (sp == 0));
    check(req, "empty", empty_o, (sp == DEPTH));
    check(req, "err", err_o, err);
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0; push_i = 0; pop_i = 0; din_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_status("R1", DEPTH, 1'b0);
    check("R1", "dout", dout_o, 0);
  endtask

  task automatic t_fill_and_overflow;
    for (int i = 0; i < DEPTH; i++) begin
      step(1'b1, 1'b0, WIDTH'(16'hA000 + i));
      check_status("R2", DEPTH - 1 - i, 1'b0);
    end
    check("R4", "full after fill", full_o, 1);
    step(1'b1, 1'b0, WIDTH'(16'hDEAD));
    check_status("R6", 0, 1'b1);
    @(negedge clk);
    check("R6", "err one cycle", err_o, 0);
  endtask

  task automatic t_drain_and_underflow;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      step(1'b0, 1'b1, '0);
      check("R9", "pop order", dout_o, 16'hA000 + i);
      check_status("R3", DEPTH - i, 1'b0);
    end
    check("R5", "empty after drain", empty_o, 1);
    step(1'b0, 1'b1, '0);
    check_status("R7", DEPTH, 1'b1);
    check("R7", "dout unchanged", dout_o, 16'hA000);
    @(negedge clk);
    check("R7", "err one cycle", err_o, 0);
  endtask

  task automatic t_both;
    step(1'b1, 1'b0, WIDTH'(16'h0011));
    step(1'b1, 1'b0, WIDTH'(16'h0022));
    step(1'b1, 1'b1, WIDTH'(16'h0033));
    check("R8", "dout on both", dout_o, 16'h0022);
    check_status("R8", DEPTH - 1, 1'b0);
    step(1'b0, 1'b1, '0);
    check("R8", "push not stored", dout_o, 16'h0011);
    check_status("R8", DEPTH, 1'b0);
    step(1'b1, 1'b1, WIDTH'(16'h0044));
    check_status("R8", DEPTH, 1'b1);
    check("R8", "dout on empty both", dout_o, 16'h0011);
  endtask

  task automatic t_hold;
    step(1'b1, 1'b0, WIDTH'(16'h5A5A));
    step(1'b1, 1'b0, WIDTH'(16'h3C3C));
    check("R10", "dout held across push", dout_o, 16'h0011);
    step(1'b0, 1'b1, '0);
    check("R9", "last in first out", dout_o, 16'h3C3C);
    repeat (4) @(negedge clk);
    check("R10", "dout held idle", dout_o, 16'h3C3C);
    check_status("R10", DEPTH - 1, 1'b0);
    step(1'b0, 1'b1, '0);
    check("R9", "second out", dout_o, 16'h5A5A);
    check("R5", "empty again", empty_o, 1);
  endtask

  initial begin
    push_i = 0; pop_i = 0; din_i = '0; rst_n = 1'b0;
    t_reset();
    t_fill_and_overflow();
    t_drain_and_underflow();
    t_both();
    t_hold();
    t_reset();
    done = 1;
  end

  initial begin
    for (int c = 0; c < 5000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule